// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for an external integrating (dual-slope) analog front end. It runs one conversion at a time through four analog phases. It drives the two phase-select lines that steer the front end's switches, and it watches the front end's single zero-crossing comparator. A start pulse launches a conversion. The block then times an auto-zero interval and a fixed integrate interval, and samples the comparator at the end of integrate to get the sign. It then counts clock cycles during de-integration until the comparator falls. Finally it holds the integrator-zero phase until the comparator recovers, and after that it parks in auto zero, which is the idle state.

The result is a magnitude count with a sign bit, an overrange flag and an integrator-zero error flag. It is presented on a valid/ready output. Once raised, `res_valid` stays high and the result fields stay frozen until a cycle in which `res_ready` is high. While a result is waiting, new start pulses are dropped, so back-pressure from the consumer stalls the next conversion and never overwrites data. The comparator input is asynchronous and passes through a two-flop synchroniser. The latency this adds, together with any external delay, can be removed through a programmable compensation value that is subtracted from the count.

The block also drives a 2-bit channel select for an optional four-way input multiplexer. The value is captured only when a conversion is accepted, which is while the front end is in auto zero.

Top module: `dual_slope_seq`

## Requirements
- R1: `phase_sel[1]` is the first control line (MSB). The codes are 00 integrator zero, 01 auto zero, 10 integrate, 11 de-integrate. After reset, `phase_sel` is 01, `busy` is 0 and `res_valid` is 0.
- R2: A conversion always moves through the phases in the order auto zero, integrate, de-integrate, integrator zero, and then back to the auto-zero idle state.
- R3: A start pulse is accepted only while idle with no pending result, and `busy` is high in the following cycle. The timed auto-zero interval lasts `az_ticks` cycles, or the effective integrate length when `az_ticks` is 0. A start pulse while busy is ignored.
- R4: Integrate lasts exactly `int_ticks` cycles (0 counts as 1). The cycle after the last integrate cycle is always de-integrate.
- R5: `res_sign` is the synchronised comparator level in the last integrate cycle, where 1 means positive. Earlier toggles during integrate have no effect.
- R6: The raw count is the number of de-integrate cycles that pass before the synchronised falling edge is seen. A comparator fall driven k cycles into de-integrate gives a raw count of k+2, and de-integrate then lasts k+3 cycles. `res_mag` is the raw count minus `lat_comp`, saturating at 0.
- R7: If no falling edge is seen by raw count 2×(effective integrate length), the result is overrange. In that case `res_ovr` is 1, `res_mag` is 2×(effective integrate length), and de-integrate lasts that count plus one cycle. A fall seen exactly at the limit is a normal result.
- R8: Integrator zero drives 00 until the synchronised comparator is high. In the very next cycle `phase_sel` is 01 and `res_valid` is 1. A rise driven m cycles into this phase ends it after m+3 cycles.
- R9: If the comparator has not returned high within `iz_ticks` cycles (0 counts as 1) of integrator zero, the block still returns to auto zero and sets `res_izerr` to 1. Otherwise `res_izerr` is 0.
- R10: `chan_sel` takes the value of `chan_req` when a start is accepted (00 is channel 1, 11 is channel 4) and holds it outside auto zero.
- R11: While `res_valid` is high and `res_ready` is low, all result fields hold steady and start pulses are ignored. A cycle with `res_ready` high clears `res_valid`.
- R12: Comparator activity during auto zero has no effect on phase timing or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request pulse |
| chan_req | input | 2 | Requested multiplexer channel |
| int_ticks | input | CNT_W | Integrate length in cycles |
| az_ticks | input | CNT_W | Auto-zero length in cycles, 0 means the same as integrate |
| iz_ticks | input | CNT_W | Integrator-zero timeout in cycles |
| lat_comp | input | LAT_W | Count subtracted from the raw magnitude |
| cmp_async | input | 1 | Asynchronous zero-crossing comparator |
| phase_sel | output | 2 | Phase-select lines to the front end |
| chan_sel | output | 2 | Channel select to the input multiplexer |
| busy | output | 1 | Conversion in progress |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts result |
| res_mag | output | CNT_W+1 | Compensated magnitude |
| res_sign | output | 1 | Sign, 1 for positive |
| res_ovr | output | 1 | De-integrate limit reached |
| res_izerr | output | 1 | Integrator-zero timeout occurred |

## Verification
The hardest situations to reach from the ports are the exact-boundary ones. These are a comparator fall that the synchroniser delivers in the very cycle the de-integrate limit is reached, and a comparator recovery that arrives in the last allowed integrator-zero cycle. The stimulus reaches them by watching `phase_sel` and driving the comparator at chosen cycle offsets within each phase. Each offset is chosen with the two synchroniser flops already counted, so the edge lands on the intended cycle. Noise during auto zero and early integrate is injected by toggling the comparator in those phases, and back-pressure is applied by holding `res_ready` low while start pulses are issued.

// File: rtl/dss_pkg.sv
`timescale 1ns/1ps
package dss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZ,
    ST_INT,
    ST_DEI,
    ST_IZ
  } seq_st_t;

  localparam logic [1:0] PH_ZERO  = 2'b00;
  localparam logic [1:0] PH_AZERO = 2'b01;
  localparam logic [1:0] PH_INTEG = 2'b10;
  localparam logic [1:0] PH_DEINT = 2'b11;

  function automatic logic [1:0] phase_of(seq_st_t s);
    case (s)
      ST_INT:  return PH_INTEG;
      ST_DEI:  return PH_DEINT;
      ST_IZ:   return PH_ZERO;
      default: return PH_AZERO;
    endcase
  endfunction
endpackage

// File: rtl/dss_cmp_sync.sv
`timescale 1ns/1ps
module dss_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_async,
  output logic cmp_s,
  output logic cmp_fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= cmp_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign cmp_s    = chain[STAGES-1];
  assign cmp_fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/dss_seq_ctrl.sv
`timescale 1ns/1ps
module dss_seq_ctrl
  import dss_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold,
  input  logic [CNT_W-1:0] int_ticks,
  input  logic [CNT_W-1:0] az_ticks,
  input  logic [CNT_W-1:0] iz_ticks,
  input  logic             cmp_s,
  input  logic             cmp_fall,
  output logic [1:0]       phase_sel,
  output logic             busy,
  output logic             accept,
  output logic             sign_stb,
  output logic             cap_stb,
  output logic             ovr_stb,
  output logic             done_stb,
  output logic             iz_err,
  output logic [CNT_W:0]   cnt,
  output logic [CNT_W:0]   lim
);
  localparam int CW1 = CNT_W + 1;

  seq_st_t          st, nxt;
  logic             clr;
  logic [CNT_W-1:0] int_eff, az_eff, iz_eff;

  assign int_eff = (int_ticks == '0) ? CNT_W'(1) : int_ticks;
  assign az_eff  = (az_ticks  == '0) ? int_eff   : az_ticks;
  assign iz_eff  = (iz_ticks  == '0) ? CNT_W'(1) : iz_ticks;
  assign lim     = {int_eff, 1'b0};

  always_comb begin
    nxt      = st;
    clr      = 1'b0;
    accept   = 1'b0;
    sign_stb = 1'b0;
    cap_stb  = 1'b0;
    ovr_stb  = 1'b0;
    done_stb = 1'b0;
    iz_err   = 1'b0;
    case (st)
      ST_IDLE: if (start && !hold) begin
        accept = 1'b1;
        nxt    = ST_AZ;
        clr    = 1'b1;
      end
      ST_AZ: if (cnt == CW1'(az_eff) - CW1'(1)) begin
        nxt = ST_INT;
        clr = 1'b1;
      end
      ST_INT: if (cnt == CW1'(int_eff) - CW1'(1)) begin
        sign_stb = 1'b1;
        nxt      = ST_DEI;
        clr      = 1'b1;
      end
      ST_DEI: if (cmp_fall) begin
        cap_stb = 1'b1;
        nxt     = ST_IZ;
        clr     = 1'b1;
      end else if (cnt == lim) begin
        ovr_stb = 1'b1;
        nxt     = ST_IZ;
        clr     = 1'b1;
      end
      ST_IZ: if (cmp_s) begin
        done_stb = 1'b1;
        nxt      = ST_IDLE;
        clr      = 1'b1;
      end else if (cnt == CW1'(iz_eff) - CW1'(1)) begin
        done_stb = 1'b1;
        iz_err   = 1'b1;
        nxt      = ST_IDLE;
        clr      = 1'b1;
      end
      default: begin
        nxt = ST_IDLE;
        clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (clr)                cnt <= '0;
      else if (st != ST_IDLE) cnt <= cnt + CW1'(1);
    end

  assign phase_sel = phase_of(st);
  assign busy      = (st != ST_IDLE);

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_sel != $past(phase_sel)) |->
      (($past(phase_sel) == PH_AZERO && phase_sel == PH_INTEG) ||
       ($past(phase_sel) == PH_INTEG && phase_sel == PH_DEINT) ||
       ($past(phase_sel) == PH_DEINT && phase_sel == PH_ZERO)  ||
       ($past(phase_sel) == PH_ZERO  && phase_sel == PH_AZERO))); // R2

  AST_INT_THEN_DEINT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_sel == PH_INTEG) |=> (phase_sel == PH_INTEG || phase_sel == PH_DEINT)); // R4

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase_sel != PH_ZERO) |=> busy); // R3
endmodule

// File: rtl/dss_result.sv
`timescale 1ns/1ps
module dss_result #(
  parameter int CNT_W = 16,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sign_stb,
  input  logic             sign_val,
  input  logic             cap_stb,
  input  logic             ovr_stb,
  input  logic             done_stb,
  input  logic             iz_err,
  input  logic [CNT_W:0]   cnt,
  input  logic [CNT_W:0]   lim,
  input  logic [LAT_W-1:0] lat_comp,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [CNT_W:0]   res_mag,
  output logic             res_sign,
  output logic             res_ovr,
  output logic             res_izerr
);
  localparam int CW1 = CNT_W + 1;

  logic [CNT_W:0] lat_ext, comp_cnt;

  assign lat_ext  = CW1'(lat_comp);
  assign comp_cnt = (cnt > lat_ext) ? (cnt - lat_ext) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_mag   <= '0;
      res_sign  <= 1'b0;
      res_ovr   <= 1'b0;
      res_izerr <= 1'b0;
    end else begin
      if (sign_stb) res_sign <= sign_val;
      if (cap_stb) begin
        res_mag <= comp_cnt;
        res_ovr <= 1'b0;
      end else if (ovr_stb) begin
        res_mag <= lim;
        res_ovr <= 1'b1;
      end
      if (done_stb) begin
        res_valid <= 1'b1;
        res_izerr <= iz_err;
      end else if (res_valid && res_ready) begin
        res_valid <= 1'b0;
      end
    end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_mag) && $stable(res_sign) &&
       $stable(res_ovr) && $stable(res_izerr))); // R11
endmodule

// File: rtl/dual_slope_seq.sv
`timescale 1ns/1ps
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LAT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       chan_req,
  input  logic [CNT_W-1:0] int_ticks,
  input  logic [CNT_W-1:0] az_ticks,
  input  logic [CNT_W-1:0] iz_ticks,
  input  logic [LAT_W-1:0] lat_comp,
  input  logic             cmp_async,
  output logic [1:0]       phase_sel,
  output logic [1:0]       chan_sel,
  output logic             busy,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CNT_W:0]   res_mag,
  output logic             res_sign,
  output logic             res_ovr,
  output logic             res_izerr
);
  logic           cmp_s, cmp_fall;
  logic           accept, sign_stb, cap_stb, ovr_stb, done_stb, iz_err;
  logic [CNT_W:0] cnt, lim;

  dss_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_async(cmp_async),
    .cmp_s    (cmp_s),
    .cmp_fall (cmp_fall)
  );

  dss_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .hold     (res_valid),
    .int_ticks(int_ticks),
    .az_ticks (az_ticks),
    .iz_ticks (iz_ticks),
    .cmp_s    (cmp_s),
    .cmp_fall (cmp_fall),
    .phase_sel(phase_sel),
    .busy     (busy),
    .accept   (accept),
    .sign_stb (sign_stb),
    .cap_stb  (cap_stb),
    .ovr_stb  (ovr_stb),
    .done_stb (done_stb),
    .iz_err   (iz_err),
    .cnt      (cnt),
    .lim      (lim)
  );

  dss_result #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .sign_stb (sign_stb),
    .sign_val (cmp_s),
    .cap_stb  (cap_stb),
    .ovr_stb  (ovr_stb),
    .done_stb (done_stb),
    .iz_err   (iz_err),
    .cnt      (cnt),
    .lim      (lim),
    .lat_comp (lat_comp),
    .res_ready(res_ready),
    .res_valid(res_valid),
    .res_mag  (res_mag),
    .res_sign (res_sign),
    .res_ovr  (res_ovr),
    .res_izerr(res_izerr)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      chan_sel <= 2'b00;
    else if (accept) chan_sel <= chan_req;

  AST_IZ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_sel == PH_ZERO && cmp_s) |=> (phase_sel == PH_AZERO && res_valid)); // R8

  AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_sel != PH_AZERO) |-> $stable(chan_sel)); // R10

  AST_IDLE_IS_AZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (phase_sel == PH_AZERO)); // R1
endmodule

// File: tb/dual_slope_seq_bench.sv
`timescale 1ns/1ps
module dual_slope_seq_bench;
  localparam int CNT_W = 16;
  localparam int LAT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [1:0]       chan_req;
  logic [CNT_W-1:0] int_ticks, az_ticks, iz_ticks;
  logic [LAT_W-1:0] lat_comp;
  logic             cmp_async;
  logic [1:0]       phase_sel, chan_sel;
  logic             busy, res_valid, res_ready;
  logic [CNT_W:0]   res_mag;
  logic             res_sign, res_ovr, res_izerr;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_slope_seq #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_dual_slope_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_req(chan_req),
    .int_ticks(int_ticks), .az_ticks(az_ticks), .iz_ticks(iz_ticks),
    .lat_comp(lat_comp), .cmp_async(cmp_async), .phase_sel(phase_sel),
    .chan_sel(chan_sel), .busy(busy), .res_valid(res_valid),
    .res_ready(res_ready), .res_mag(res_mag), .res_sign(res_sign),
    .res_ovr(res_ovr), .res_izerr(res_izerr)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // columns: int_ticks, az_ticks, lat_comp, sign, fall offset (-1 none),
  //          rise offset in integrator zero (-1 none), iz_ticks, channel
  localparam int NV = 7;
  localparam int VT [NV][8] = '{
    '{ 8, 0,  0, 1,  5,  2, 20, 0},
    '{ 6, 3,  2, 0,  9,  1, 20, 2},
    '{10, 5, 30, 1,  4,  3, 20, 3},
    '{ 5, 2,  0, 1, -1,  0, 20, 1},
    '{ 4, 4,  1, 0,  6,  0,  3, 1},
    '{ 6, 2,  0, 1,  3, -1,  5, 2},
    '{ 7, 0,  3, 0,  8,  4, 30, 0}
  };

  task automatic run_vec(input int it, input int az, input int lat, input int sg,
                         input int d, input int m, input int iz, input int ch);
    int ieff, aeff, zeff, lim, raw, emag, eovr, eiz, ezerr, edei;
    int n, i, k, j;
    int held;
    ieff = (it == 0) ? 1 : it;
    aeff = (az == 0) ? ieff : az;
    zeff = (iz == 0) ? 1 : iz;
    lim  = 2 * ieff;
    if (d < 0) begin
      eovr = 1; emag = lim; edei = lim + 1;
    end else begin
      raw  = d + 2;
      eovr = 0; emag = (raw > lat) ? raw - lat : 0; edei = d + 3;
    end
    if (d < 0) begin
      eiz = 1; ezerr = 0;
    end else if (m >= 0 && m + 2 <= zeff - 1) begin
      eiz = m + 3; ezerr = 0;
    end else begin
      eiz = zeff; ezerr = 1;
    end

    @(negedge clk);
    int_ticks = 16'(it); az_ticks = 16'(az); iz_ticks = 16'(iz);
    lat_comp = 8'(lat); chan_req = 2'(ch); cmp_async = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 busy after start", int'(busy), 1);

    n = 0;
    while (phase_sel == 2'b01) begin
      cmp_async = n[0];                     // R12 noise in auto zero
      n++;
      @(negedge clk);
    end
    check("R3 auto-zero length", n, aeff);
    check("R2 auto zero then integrate", int'(phase_sel), 2);

    i = 0;
    while (phase_sel == 2'b10) begin
      start = (i == 1);                     // R3 ignored while busy
      if (i == 1) chan_req = ~2'(ch);       // R10 change mid-run
      if (i < ieff - 3) cmp_async = i[0] ? sg[0] : ~sg[0];
      else              cmp_async = sg[0];
      i++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R4 integrate length", i, ieff);
    check("R4 de-integrate follows", int'(phase_sel), 3);

    k = 0;
    while (phase_sel == 2'b11) begin
      if (k == 0) cmp_async = 1'b1;
      if (k == d) cmp_async = 1'b0;
      k++;
      @(negedge clk);
    end
    check(eovr ? "R7 de-integrate length" : "R6 de-integrate length", k, edei);
    check("R2 integrator zero follows", int'(phase_sel), 0);

    j = 0;
    while (phase_sel == 2'b00) begin
      if (j == m) cmp_async = 1'b1;
      j++;
      @(negedge clk);
    end
    check(ezerr ? "R9 zero-phase length" : "R8 zero-phase length", j, eiz);
    check("R8 back to auto zero", int'(phase_sel), 1);
    check("R8 valid on return", int'(res_valid), 1);
    check("R3 idle after conversion", int'(busy), 0);
    check("R5 sign", int'(res_sign), sg);
    check("R6 magnitude", int'(res_mag), emag);
    check("R7 overrange flag", int'(res_ovr), eovr);
    check("R9 zero-phase error flag", int'(res_izerr), ezerr);
    check("R10 channel latched", int'(chan_sel), ch);

    held = int'(res_mag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 start ignored while result pending", int'(busy), 0);
    check("R11 valid held", int'(res_valid), 1);
    check("R11 magnitude held", int'(res_mag), held);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R11 valid cleared by ready", int'(res_valid), 0);
    check("R11 no conversion started", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; chan_req = 2'b00; res_ready = 1'b0;
    int_ticks = 16'd8; az_ticks = 16'd0; iz_ticks = 16'd20; lat_comp = 8'd0;
    cmp_async = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset phase", int'(phase_sel), 1);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset valid", int'(res_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle phase after reset", int'(phase_sel), 1);
    check("R12 comparator in idle starts nothing", int'(busy), 0);

    for (int v = 0; v < NV; v++)
      run_vec(VT[v][0], VT[v][1], VT[v][2], VT[v][3],
              VT[v][4], VT[v][5], VT[v][6], VT[v][7]);

    // Directed: a long idle with comparator chatter, then a repeat of vector 0
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      cmp_async = t[1];
    end
    check("R12 chatter while idle", int'(busy), 0);
    run_vec(VT[0][0], VT[0][1], VT[0][2], VT[0][3],
            VT[0][4], VT[0][5], VT[0][6], VT[0][7]);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule